// File: doc/BRIEF.md
# Constant Off-Time Hysteretic Gate Controller

This block holds the cycle-by-cycle switching logic of a peak-current converter that uses a constant off-time. It drives the power switch gate. It also drives a discharge output that resets the off-time capacitor. The switching period does not come from the clock. An on-time ends when the peak-current comparator trips, or when the current-limit comparator trips. An off-time ends when the timing-capacitor comparator reports that the threshold has been reached. The clock only measures the guard intervals: leading-edge blanking, the minimum discharge time, the off-time watchdog and the current-limit lockout.

The controller is a five-state machine:

- **ST_IDLE**: disabled. Gate is low and discharge is high.
- **ST_DISCH**: capacitor reset for a minimum time. Gate is low and discharge is high.
- **ST_ON**: gate is high. The state opens with a blanking window.
- **ST_OFF**: gate is low and the capacitor is free to charge.
- **ST_LOCK**: hold-off after a current-limit trip. Gate is low and discharge is high.

The transitions are:

- **T_WAKE**: ST_IDLE to ST_DISCH, when enable is high.
- **T_FIRE**: ST_DISCH to ST_ON, when the discharge time has elapsed.
- **T_PEAK**: ST_ON to ST_OFF, when the peak flag is seen after blanking.
- **T_LIMIT**: ST_ON to ST_LOCK, when the current-limit flag is seen after blanking.
- **T_REARM**: ST_OFF to ST_DISCH, when the capacitor threshold is reached or the watchdog expires.
- **T_RELEASE**: ST_LOCK to ST_DISCH, when the lockout has elapsed.
- **T_KILL**: any state to ST_IDLE, when enable is low.

All comparator inputs are assumed to be synchronous to `clk`.

Top module: `cot_gate_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with `enable_i` low, `gate_o` is 0 and `discharge_o` is 1.
- R2: From ST_IDLE with `enable_i` high, `discharge_o` stays high for the ST_IDLE cycle plus exactly DISCH_CYC further cycles. `gate_o` then rises at the same edge at which `discharge_o` falls. The gate never rises unless discharge was high in the previous cycle.
- R3: During the first BLANK_CYC cycles of every on-time, `peak_hit_i` and `ilim_hit_i` are ignored. The shortest possible on-time is therefore BLANK_CYC+1 cycles.
- R4: After blanking, a cycle with `peak_hit_i`=1 and `ilim_hit_i`=0 ends the on-time at the following edge. After that edge `gate_o`=0 and `discharge_o`=0, which is the off-time.
- R5: After blanking, a cycle with `ilim_hit_i`=1 ends the on-time even if `peak_hit_i`=1 in the same cycle (current limit has priority). `discharge_o` is then held high with `gate_o` low for LOCK_CYC+DISCH_CYC cycles before the next on-time.
- R6: In the off-time, a cycle with `toff_done_i`=1 ends the off-time at the next edge and starts the ST_DISCH sequence. If `toff_done_i` is held high, each off-time lasts 1 cycle.
- R7: With `toff_done_i` never asserted, the off-time lasts exactly TOFF_MAX_CYC cycles, and then a new discharge and on-time are forced.
- R8: `enable_i`=0 forces `gate_o` low in the same cycle. From the next edge onward, `discharge_o` is high until re-enable.
- R9: `gate_o` and `discharge_o` are never high in the same cycle.
- R10: `toff_done_i` has no effect outside the off-time. With `peak_hit_i`=0 and `toff_done_i`=1, the gate stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock for the guard intervals |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Run permission from the protection logic |
| peak_hit_i | input | 1 | Sensed current at or above the controlled reference |
| ilim_hit_i | input | 1 | Sensed current at or above the hard current limit |
| toff_done_i | input | 1 | Off-time capacitor at its threshold |
| gate_o | output | 1 | Power switch gate command, high = on |
| discharge_o | output | 1 | Off-time capacitor reset, high = discharge |

## Verification
The checker watches four properties on every cycle:
- gate and discharge are mutually exclusive;
- the gate is low and discharge is high after any cycle with enable low;
- every completed on-time lasts at least the blanking length plus one, and every discharge pulse that ends meets its minimum;
- no off-time runs past the watchdog and every gate rise follows a discharge cycle.

Some behaviours can only be shown by the bench's scenarios:
- the exact lengths of a watchdog-terminated off-time and of the current-limit hold-off;
- current limit winning over a simultaneous peak event;
- a capacitor-threshold flag being ignored during the on-time.

A cycle model run under random comparator activity covers every transition.

// File: rtl/cot_pkg.sv
package cot_pkg;

    // Controller states; see BRIEF for the transition names.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DISCH = 3'd1,
        ST_ON    = 3'd2,
        ST_OFF   = 3'd3,
        ST_LOCK  = 3'd4
    } cot_state_e;

    function automatic int cot_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cot_dncnt.sv
module cot_dncnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cot_flag_qual.sv
module cot_flag_qual
    import cot_pkg::*;
(
    input  cot_state_e st_i,
    input  logic       cnt_zero_i,
    input  logic       peak_hit_i,
    input  logic       ilim_hit_i,
    output logic       ilim_q_o,
    output logic       peak_q_o
);

    // Flags only count in the on-time once the blanking window is over.
    logic sense_open;

    always_comb begin
        sense_open = (st_i == ST_ON) && cnt_zero_i;
        ilim_q_o   = sense_open && ilim_hit_i;
        // Current limit wins over a simultaneous peak event.
        peak_q_o   = sense_open && peak_hit_i && !ilim_hit_i;
    end

endmodule

// File: rtl/cot_fsm.sv
module cot_fsm
    import cot_pkg::*;
#(
    parameter int W            = 8,
    parameter int BLANK_CYC    = 12,
    parameter int DISCH_CYC    = 4,
    parameter int TOFF_MAX_CYC = 100,
    parameter int LOCK_CYC     = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable_i,
    input  logic         ilim_q_i,
    input  logic         peak_q_i,
    input  logic         toff_done_i,
    input  logic         cnt_zero_i,
    output cot_state_e   st_o,
    output logic         load_o,
    output logic [W-1:0] load_val_o,
    output logic         gate_o,
    output logic         discharge_o
);

    localparam logic [W-1:0] LD_DISCH = W'(DISCH_CYC - 1);
    localparam logic [W-1:0] LD_BLANK = W'(BLANK_CYC);
    localparam logic [W-1:0] LD_TOFF  = W'(TOFF_MAX_CYC - 1);
    localparam logic [W-1:0] LD_LOCK  = W'(LOCK_CYC - 1);

    cot_state_e st_q, st_nxt;

    // Next state and counter load
    always_comb begin
        st_nxt     = st_q;
        load_o     = 1'b0;
        load_val_o = '0;
        if (!enable_i) begin
            st_nxt = ST_IDLE;                       // T_KILL
        end else begin
            unique case (st_q)
                ST_IDLE: begin                      // T_WAKE
                    st_nxt     = ST_DISCH;
                    load_o     = 1'b1;
                    load_val_o = LD_DISCH;
                end
                ST_DISCH: begin
                    if (cnt_zero_i) begin           // T_FIRE
                        st_nxt     = ST_ON;
                        load_o     = 1'b1;
                        load_val_o = LD_BLANK;
                    end
                end
                ST_ON: begin
                    if (ilim_q_i) begin             // T_LIMIT
                        st_nxt     = ST_LOCK;
                        load_o     = 1'b1;
                        load_val_o = LD_LOCK;
                    end else if (peak_q_i) begin    // T_PEAK
                        st_nxt     = ST_OFF;
                        load_o     = 1'b1;
                        load_val_o = LD_TOFF;
                    end
                end
                ST_OFF: begin
                    if (toff_done_i || cnt_zero_i) begin  // T_REARM
                        st_nxt     = ST_DISCH;
                        load_o     = 1'b1;
                        load_val_o = LD_DISCH;
                    end
                end
                ST_LOCK: begin
                    if (cnt_zero_i) begin           // T_RELEASE
                        st_nxt     = ST_DISCH;
                        load_o     = 1'b1;
                        load_val_o = LD_DISCH;
                    end
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Outputs
    always_comb begin
        gate_o      = 1'b0;
        discharge_o = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_DISCH, ST_LOCK: discharge_o = 1'b1;
            ST_ON:                      gate_o      = enable_i;
            ST_OFF:                     ;
            default:                    discharge_o = 1'b1;
        endcase
    end

    assign st_o = st_q;

endmodule

// File: rtl/cot_gate_ctrl.sv
module cot_gate_ctrl
    import cot_pkg::*;
#(
    parameter int BLANK_CYC    = 12,
    parameter int DISCH_CYC    = 4,
    parameter int TOFF_MAX_CYC = 14000,
    parameter int LOCK_CYC     = 14000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic peak_hit_i,
    input  logic ilim_hit_i,
    input  logic toff_done_i,
    output logic gate_o,
    output logic discharge_o
);

    localparam int LONGEST = cot_max(cot_max(BLANK_CYC, DISCH_CYC),
                                     cot_max(TOFF_MAX_CYC, LOCK_CYC));
    localparam int CNT_W   = $clog2(LONGEST + 1);

    cot_state_e       st;
    logic             cnt_zero;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_load_val;
    logic             ilim_q;
    logic             peak_q;

    cot_dncnt #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cnt_load_val),
        .zero_o     (cnt_zero)
    );

    cot_flag_qual u_qual (
        .st_i       (st),
        .cnt_zero_i (cnt_zero),
        .peak_hit_i (peak_hit_i),
        .ilim_hit_i (ilim_hit_i),
        .ilim_q_o   (ilim_q),
        .peak_q_o   (peak_q)
    );

    cot_fsm #(
        .W            (CNT_W),
        .BLANK_CYC    (BLANK_CYC),
        .DISCH_CYC    (DISCH_CYC),
        .TOFF_MAX_CYC (TOFF_MAX_CYC),
        .LOCK_CYC     (LOCK_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .ilim_q_i    (ilim_q),
        .peak_q_i    (peak_q),
        .toff_done_i (toff_done_i),
        .cnt_zero_i  (cnt_zero),
        .st_o        (st),
        .load_o      (cnt_load),
        .load_val_o  (cnt_load_val),
        .gate_o      (gate_o),
        .discharge_o (discharge_o)
    );

endmodule

// File: rtl/cot_gate_ctrl_chk.sv
module cot_gate_ctrl_chk #(
    parameter int BLANK_CYC    = 12,
    parameter int DISCH_CYC    = 4,
    parameter int TOFF_MAX_CYC = 14000,
    parameter int LOCK_CYC     = 14000
) (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic peak_hit_i,
    input logic ilim_hit_i,
    input logic toff_done_i,
    input logic gate_o,
    input logic discharge_o
);

    logic [31:0] on_len, dis_len, off_len;
    logic        unused_in;

    assign unused_in = peak_hit_i ^ ilim_hit_i ^ toff_done_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_len  <= '0;
            dis_len <= '0;
            off_len <= '0;
        end else begin
            on_len  <= gate_o      ? on_len + 32'd1  : 32'd0;
            dis_len <= discharge_o ? dis_len + 32'd1 : 32'd0;
            off_len <= (!gate_o && !discharge_o) ? off_len + 32'd1 : 32'd0;
        end
    end

    AST_GATE_DISCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o && discharge_o));                                        // R9
    AST_DISABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !gate_o);                                           // R8
    AST_DISABLE_DISCH: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> discharge_o);                                       // R8
    AST_MIN_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_o) && enable_i) |-> (on_len >= 32'(BLANK_CYC + 1)));  // R3
    AST_DISCH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(discharge_o) |-> (dis_len >= 32'(DISCH_CYC)));              // R2
    AST_OFF_WATCHDOG: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_o && !discharge_o && enable_i) |-> (off_len < 32'(TOFF_MAX_CYC))); // R7
    AST_ON_AFTER_DISCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(discharge_o));                            // R2

    initial begin
        AST_LOCK_PARAM: assert (LOCK_CYC >= 1 && DISCH_CYC >= 1 && TOFF_MAX_CYC >= 1); // R5
    end

endmodule

bind cot_gate_ctrl cot_gate_ctrl_chk #(
    .BLANK_CYC    (BLANK_CYC),
    .DISCH_CYC    (DISCH_CYC),
    .TOFF_MAX_CYC (TOFF_MAX_CYC),
    .LOCK_CYC     (LOCK_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .peak_hit_i  (peak_hit_i),
    .ilim_hit_i  (ilim_hit_i),
    .toff_done_i (toff_done_i),
    .gate_o      (gate_o),
    .discharge_o (discharge_o)
);

// File: tb/cot_gate_ctrl_bench.sv
module cot_gate_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BLANK = 4;
    localparam int DISCH = 3;
    localparam int TOFF  = 40;
    localparam int LOCK  = 60;

    localparam int M_IDLE = 0, M_DISCH = 1, M_ON = 2, M_OFF = 3, M_LOCK = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, pk = 1'b0, il = 1'b0, td = 1'b0;
    logic gate, disch;

    always #(CLK_PERIOD/2) clk = ~clk;

    cot_gate_ctrl #(
        .BLANK_CYC(BLANK), .DISCH_CYC(DISCH), .TOFF_MAX_CYC(TOFF), .LOCK_CYC(LOCK)
    ) u_cot_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .enable_i(en), .peak_hit_i(pk),
        .ilim_hit_i(il), .toff_done_i(td), .gate_o(gate), .discharge_o(disch)
    );

    int checks = 0, errors = 0;
    int m_st = M_IDLE, m_cnt = 0;
    int on_cur = 0, on_last = 0, off_cur = 0, off_last = 0, dis_cur = 0, dis_last = 0;
    logic s_g = 1'b0, s_d = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string st_tag(input int s);
        case (s)
            M_IDLE:  return "R8 idle outputs";
            M_DISCH: return "R2 discharge outputs";
            M_ON:    return "R4 on-time outputs";
            M_OFF:   return "R6 off-time outputs";
            default: return "R5 lockout outputs";
        endcase
    endfunction

    function automatic int exp_out(input int s, input bit e);
        int g, d;
        g = (s == M_ON && e) ? 1 : 0;
        d = (s == M_IDLE || s == M_DISCH || s == M_LOCK) ? 1 : 0;
        return g * 2 + d;
    endfunction

    // Reference model derived from the requirements
    task automatic model_tick(input bit e, input bit p, input bit l, input bit t);
        if (!e) begin
            m_st = M_IDLE;
        end else begin
            case (m_st)
                M_IDLE: begin m_st = M_DISCH; m_cnt = DISCH - 1; end
                M_DISCH: if (m_cnt == 0) begin m_st = M_ON; m_cnt = BLANK; end
                         else m_cnt--;
                M_ON: if (m_cnt != 0) m_cnt--;
                      else if (l) begin m_st = M_LOCK; m_cnt = LOCK - 1; end
                      else if (p) begin m_st = M_OFF; m_cnt = TOFF - 1; end
                M_OFF: if (t || m_cnt == 0) begin m_st = M_DISCH; m_cnt = DISCH - 1; end
                       else m_cnt--;
                default: if (m_cnt == 0) begin m_st = M_DISCH; m_cnt = DISCH - 1; end
                         else m_cnt--;
            endcase
        end
    endtask

    task automatic step(input bit e, input bit p, input bit l, input bit t);
        en = e; pk = p; il = l; td = t;
        #1;
        s_g = gate; s_d = disch;
        chk(st_tag(m_st), int'(s_g) * 2 + int'(s_d), exp_out(m_st, e));
        chk("R9 exclusive", int'(s_g && s_d), 0);
        if (s_g) on_cur++; else if (on_cur > 0) begin on_last = on_cur; on_cur = 0; end
        if (!s_g && !s_d) off_cur++; else if (off_cur > 0) begin off_last = off_cur; off_cur = 0; end
        if (s_d) dis_cur++; else if (dis_cur > 0) begin dis_last = dis_cur; dis_cur = 0; end
        @(posedge clk);
        model_tick(e, p, l, t);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog R1..all actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C0F7));
        repeat (3) @(negedge clk);
        chk("R1 reset gate", int'(gate), 0);
        chk("R1 reset discharge", int'(disch), 1);
        rst_n = 1'b1;
        m_st = M_IDLE;

        // R1 / R2: disabled, then enable with peak held high
        repeat (5) step(0, 0, 0, 0);
        chk("R1 idle gate", int'(s_g), 0);
        chk("R1 idle discharge", int'(s_d), 1);
        repeat (DISCH + 2) step(1, 1, 0, 0);
        chk("R2 discharge run", dis_last, 5 + 1 + DISCH);
        chk("R2 gate rose", int'(s_g), 1);

        // R3 / R7: peak held through blanking, no capacitor flag
        repeat (60) step(1, 1, 0, 0);
        chk("R3 min on-time", on_last, BLANK + 1);
        chk("R7 watchdog off-time", off_last, TOFF);

        // R6: capacitor flag held high
        repeat (40) step(1, 1, 0, 1);
        chk("R6 off-time on threshold", off_last, 1);

        // R10: capacitor flag during on-time has no effect
        for (int i = 0; i < 100 && !s_g; i++) step(1, 0, 0, 1);
        repeat (20) step(1, 0, 0, 1);
        chk("R10 gate held", int'(s_g), 1);

        // R5: current limit with peak in the same cycle
        step(1, 1, 1, 0);
        step(1, 0, 0, 0);
        chk("R5 limit priority discharge", int'(s_d), 1);
        for (int i = 0; i < LOCK + DISCH + 10 && !s_g; i++) step(1, 0, 0, 0);
        chk("R5 hold-off length", dis_last, LOCK + DISCH);

        // R8: drop enable during on-time
        step(0, 0, 0, 0);
        chk("R8 gate same cycle", int'(s_g), 0);
        step(0, 0, 0, 0);
        chk("R8 discharge next", int'(s_d), 1);

        // Random comparator activity against the model
        for (int i = 0; i < 4000; i++) begin
            step(($urandom_range(49) != 0), ($urandom_range(5) == 0),
                 ($urandom_range(39) == 0), ($urandom_range(7) == 0));
        end

        summary();
        $finish;
    end

endmodule